// File: doc/BRIEF.md
# Fracturable Dual-Port Block RAM

This block is a synchronous RAM with one write port and one read port on a shared clock. It holds a fixed 1024-bit store. A configuration input, held steady by configuration storage outside the block, sets the shape of that store. One shape gives 128 words of 8 bits. The other gives 256 words of 4 bits. Both ports have their own address and their own enable, so a read and a write can happen in the same cycle.

The store is built as 128 rows, each split into two 4-bit lanes. In the wide shape a write fills both lanes of a row and a read returns the whole row. In the narrow shape, address bit 7 picks one lane of the row that bits [6:0] select. A narrow write changes only that lane. A narrow read returns the selected lane on the low four output bits and drives zero on the upper four. The read result passes through an output register, so data appears one clock after the read is sampled.

Top module: `frac_dpram`

## Requirements
- R1: While rst_n is low and after its release, rd_data is zero until the first read completes.
- R2: With cfg_wide = 1 the block stores 128 words of 8 bits, indexed by address bits [6:0]. A read sampled with rd_en = 1 drives the addressed word on rd_data after one clock edge.
- R3: With cfg_wide = 1, bit 7 of wr_addr and rd_addr has no effect. Addresses that differ only in that bit reach the same word.
- R4: With cfg_wide = 0 the block stores 256 words of 4 bits. Write data is taken from wr_data[3:0], read data is returned on rd_data[3:0], and rd_data[7:4] reads as zero.
- R5: With cfg_wide = 0, address bits [6:0] select the row. Bit 7 = 0 selects row bits [3:0] and bit 7 = 1 selects row bits [7:4]. This placement is visible when the same row is later read with cfg_wide = 1.
- R6: With cfg_wide = 0, a write changes only the addressed 4-bit lane. The other lane of the row keeps its value, and wr_data[7:4] has no effect.
- R7: While rd_en is 0 at a clock edge, rd_data keeps its previous value.
- R8: When a read and a write in the same cycle hit the same location, the read returns the contents from before the write. Reads and writes to different locations in the same cycle both take effect.
- R9: While wr_en is 0 at a clock edge, the store does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low reset of the read output register |
| cfg_wide | input | 1 | Shape select: 1 = 128x8, 0 = 256x4; held static |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data (bits [3:0] only in the narrow shape) |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the block with its default parameters: seven row address bits and an 8-bit row. At that size the whole 256-entry narrow address space and all 128 wide rows can be swept exhaustively within the run. The bench fills every nibble in the narrow shape and reads each row back in both shapes, which exercises every lane placement. Same-cycle collisions and address-bit-7 aliasing are also within reach at this size.

// File: rtl/frac_ram_pkg.sv
package frac_ram_pkg;

    // Shape of the storage array, driven from static configuration.
    typedef enum logic {
        SHAPE_NARROW = 1'b0,
        SHAPE_WIDE   = 1'b1
    } shape_e;

    // The array always fractures into exactly two lanes.
    localparam int unsigned LANES = 2;

endpackage

// File: rtl/frac_addr_map.sv
module frac_addr_map
    import frac_ram_pkg::*;
#(
    parameter int unsigned ROW_AW = 7,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW    = ROW_AW + 1,
    localparam int unsigned NIB_W = DATA_W / LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shape_e            shape,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [ROW_AW-1:0] wr_row,
    output logic [LANES-1:0]  lane_we,
    output logic [DATA_W-1:0] wr_word,
    output logic [ROW_AW-1:0] rd_row,
    output logic              rd_lane
);

    logic wr_lane;

    always_comb begin
        wr_row  = wr_addr[ROW_AW-1:0];
        rd_row  = rd_addr[ROW_AW-1:0];
        wr_lane = wr_addr[AW-1];
        rd_lane = rd_addr[AW-1];
    end

    // Per-lane write enables and lane data: narrow replicates the low nibble.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (shape == SHAPE_WIDE) begin
                lane_we[g]                   = wr_en;
                wr_word[g*NIB_W +: NIB_W]    = wr_data[g*NIB_W +: NIB_W];
            end else begin
                lane_we[g]                   = wr_en && (wr_lane == g[0]);
                wr_word[g*NIB_W +: NIB_W]    = wr_data[NIB_W-1:0];
            end
        end
    end

    // R9: no lane is enabled without a write request
    p_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (lane_we == '0));

    // R6: a narrow write enables exactly one lane
    p_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && shape == SHAPE_NARROW) |-> ($countones(lane_we) == 1));

    // R2: a wide write enables every lane
    p_all_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && shape == SHAPE_WIDE) |-> (&lane_we));

endmodule

// File: rtl/frac_store.sv
module frac_store
    import frac_ram_pkg::*;
#(
    parameter int unsigned ROW_AW = 7,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned ROWS  = 1 << ROW_AW,
    localparam int unsigned NIB_W = DATA_W / LANES
) (
    input  logic              clk,
    input  logic [ROW_AW-1:0] wr_row,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [ROW_AW-1:0] rd_row,
    output logic [DATA_W-1:0] rd_word
);

    // One bank per lane so each lane is written by its own process.
    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [NIB_W-1:0] bank_q [ROWS];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                bank_q[wr_row] <= wr_word[g*NIB_W +: NIB_W];
            end
        end

        // Asynchronous array read; the top registers it (read-before-write).
        assign rd_word[g*NIB_W +: NIB_W] = bank_q[rd_row];
    end

endmodule

// File: rtl/frac_read_steer.sv
module frac_read_steer
    import frac_ram_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned NIB_W = DATA_W / LANES
) (
    input  shape_e            shape,
    input  logic              rd_lane,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_val
);

    always_comb begin
        rd_val = '0;
        if (shape == SHAPE_WIDE) begin
            rd_val = rd_word;
        end else begin
            rd_val[NIB_W-1:0] = rd_lane ? rd_word[NIB_W +: NIB_W]
                                        : rd_word[NIB_W-1:0];
        end
    end

endmodule

// File: rtl/frac_dpram.sv
module frac_dpram
    import frac_ram_pkg::*;
#(
    parameter int unsigned ROW_AW = 7,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW    = ROW_AW + 1,
    localparam int unsigned NIB_W = DATA_W / LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
    } out_state_t;

    shape_e            shape;
    logic [ROW_AW-1:0] wr_row;
    logic [ROW_AW-1:0] rd_row;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rd_val;
    logic              rd_lane;
    out_state_t        st_d;
    out_state_t        st_q;

    assign shape = cfg_wide ? SHAPE_WIDE : SHAPE_NARROW;

    frac_addr_map #(.ROW_AW(ROW_AW), .DATA_W(DATA_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .shape   (shape),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .wr_row  (wr_row),
        .lane_we (lane_we),
        .wr_word (wr_word),
        .rd_row  (rd_row),
        .rd_lane (rd_lane)
    );

    frac_store #(.ROW_AW(ROW_AW), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_row  (wr_row),
        .lane_we (lane_we),
        .wr_word (wr_word),
        .rd_row  (rd_row),
        .rd_word (rd_word)
    );

    frac_read_steer #(.DATA_W(DATA_W)) u_steer (
        .shape   (shape),
        .rd_lane (rd_lane),
        .rd_word (rd_word),
        .rd_val  (rd_val)
    );

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rd_data = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd_data;

    // R7: output holds while no read is sampled
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R4: a narrow read leaves the upper lane of the output at zero
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && !$past(cfg_wide)) |-> (rd_data[DATA_W-1:NIB_W] == '0));

endmodule

// File: tb/tb_frac_dpram.sv
module tb_frac_dpram;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wide = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] ref_mem [128];
    logic [1:0] ref_vld [128];
    logic [7:0] exp_out = '0;
    bit         exp_known = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_dpram dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string tag);
        if (exp_known) begin
            n_checks++;
            if (rd_data !== exp_out) begin
                n_fail++;
                $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp_out);
            end
        end
    endtask

    // One clock cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input string tag, input logic we, input logic [7:0] wa,
                        input logic [7:0] wd, input logic re, input logic [7:0] ra);
        int row;
        int lane;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        @(posedge clk);
        if (re) begin
            row = int'(ra[6:0]);
            if (cfg_wide) begin
                exp_out   = ref_mem[row];
                exp_known = (ref_vld[row] == 2'b11);
            end else begin
                lane      = int'(ra[7]);
                exp_out   = lane == 1 ? {4'h0, ref_mem[row][7:4]} : {4'h0, ref_mem[row][3:0]};
                exp_known = ref_vld[row][lane];
            end
        end
        if (we) begin
            row = int'(wa[6:0]);
            if (cfg_wide) begin
                ref_mem[row] = wd;
                ref_vld[row] = 2'b11;
            end else if (wa[7]) begin
                ref_mem[row][7:4] = wd[3:0];
                ref_vld[row][1]   = 1'b1;
            end else begin
                ref_mem[row][3:0] = wd[3:0];
                ref_vld[row][0]   = 1'b1;
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) step("R7", 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            ref_mem[i] = '0;
            ref_vld[i] = 2'b00;
        end
        repeat (3) @(negedge clk);
        // R1: output cleared during reset
        exp_out = '0; exp_known = 1'b1;
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2: wide writes and reads across several patterns
        cfg_wide = 1'b1;
        step("R2", 1'b1, 8'h00, 8'h3C, 1'b0, 8'h00);
        step("R2", 1'b1, 8'h7F, 8'hC3, 1'b0, 8'h00);
        step("R2", 1'b1, 8'h2A, 8'hFF, 1'b1, 8'h00);
        step("R2", 1'b0, 8'h00, 8'h00, 1'b1, 8'h7F);
        step("R2", 1'b0, 8'h00, 8'h00, 1'b1, 8'h2A);

        // R3: bit 7 aliases in wide mode, on both ports
        step("R3", 1'b1, 8'h85, 8'h5A, 1'b0, 8'h00);
        step("R3", 1'b0, 8'h00, 8'h00, 1'b1, 8'h05);
        step("R3", 1'b1, 8'h06, 8'h96, 1'b1, 8'h85);
        step("R3", 1'b0, 8'h00, 8'h00, 1'b1, 8'h86);

        // R7: output holds with rd_en low
        idle_cycles(3);
        step("R7", 1'b1, 8'h06, 8'h11, 1'b0, 8'h06);

        // R9: no write when wr_en is low
        step("R9", 1'b0, 8'h2A, 8'h00, 1'b1, 8'h2A);
        step("R9", 1'b0, 8'h2A, 8'h00, 1'b1, 8'h06);

        // R8: same-location collision returns old data, then new data
        step("R8", 1'b1, 8'h2A, 8'h77, 1'b1, 8'h2A);
        step("R8", 1'b0, 8'h00, 8'h00, 1'b1, 8'h2A);
        step("R8", 1'b1, 8'h10, 8'hE1, 1'b1, 8'h7F);
        step("R8", 1'b0, 8'h00, 8'h00, 1'b1, 8'h10);

        // R5/R6: narrow write lands in upper lane of a known wide row
        step("R5", 1'b1, 8'h03, 8'hA5, 1'b0, 8'h00);
        cfg_wide = 1'b0;
        step("R6", 1'b1, 8'h83, 8'hF7, 1'b0, 8'h00);
        step("R4", 1'b0, 8'h00, 8'h00, 1'b1, 8'h83);
        step("R4", 1'b0, 8'h00, 8'h00, 1'b1, 8'h03);
        cfg_wide = 1'b1;
        step("R6", 1'b0, 8'h00, 8'h00, 1'b1, 8'h03);
        if (rd_data !== 8'h75) begin
            n_fail++;
            $display("FAIL R5: rd_data=%h expected=75", rd_data);
        end
        n_checks++;

        // R4/R5/R6: fill all 256 nibbles in narrow mode
        cfg_wide = 1'b0;
        for (int a = 0; a < 256; a++)
            step("R6", 1'b1, 8'(a), 8'((a * 7 + 3) ^ 8'hF0), 1'b0, 8'h00);
        for (int a = 0; a < 256; a++)
            step("R4", 1'b0, 8'h00, 8'h00, 1'b1, 8'(a));
        // R8 in narrow mode: collision on one nibble
        step("R8", 1'b1, 8'h91, 8'h0C, 1'b1, 8'h91);
        step("R8", 1'b1, 8'h11, 8'h0D, 1'b1, 8'h91);
        step("R8", 1'b0, 8'h00, 8'h00, 1'b1, 8'h11);
        // R5: read back all rows in wide mode
        cfg_wide = 1'b1;
        for (int r = 0; r < 128; r++)
            step("R5", 1'b0, 8'h00, 8'h00, 1'b1, 8'(r));

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule